// File: doc/BRIEF.md
# Storage Key Reference/Change Updater

After an address translation has succeeded, this block updates the storage key of the page that the access touched. It holds one key per page in an internal array. The array index is the absolute address shifted right by the page size. For each request the block reads the key, sets the reference bit, and sets the change bit on a store. It also returns the permission flags, so that the caller can decide whether a cached translation may allow writes. A load or an instruction fetch to a page whose change bit is still clear returns the flags with write permission removed. The next store to that page must then come back through this block, and that store records the change.

Each request takes a read cycle followed by a write-back cycle. A busy flag holds off new requests until the write-back has finished. Two kinds of request leave both the key array and the permissions untouched: addresses at or above the installed memory limit, and page numbers outside the key array (a failed key lookup). A side port lets a host or a test write any key while the block is idle, and it reads any key at all times.

Key layout (7 bits): bits [6:3] access-control, bit 2 fetch-protect, bit 1 reference, bit 0 change. Permission flags (3 bits): bit 0 read, bit 1 write, bit 2 execute. Access kinds: 0 load, 1 store, 2 instruction fetch, 3 reserved.

Top module: `skeyUpdater`

## Requirements
- R1: After reset every key reads 0, busy is low and respValid is low.
- R2: The key updated is the one at index reqAddr >> PAGE_BITS. No other key changes.
- R3: A load (kind 0) or fetch (kind 2) to a page whose change bit (bit 0) is clear returns permOut equal to reqPerm with bit 1 (write) cleared.
- R4: A load or fetch to a page whose change bit is set returns permOut equal to reqPerm.
- R5: A store (kind 1) sets both the change bit (bit 0) and the reference bit (bit 1) of the key, and returns permOut equal to reqPerm.
- R6: A load or fetch sets the reference bit (bit 1). Access-control, fetch-protect and change bits keep their values.
- R7: A request with reqAddr >= memLimit leaves every key unchanged and returns permOut equal to reqPerm.
- R8: A request below memLimit whose page number is NUM_PAGES or more fails the key lookup. It leaves every key unchanged and returns permOut equal to reqPerm.
- R9: A request is accepted when reqValid is high and busy is low. Busy is then high for exactly two cycles. respValid pulses for one cycle in the first cycle after busy falls, and that cycle carries the result.
- R10: A reqValid seen while busy is high is ignored.
- R11: A host write (hostWrEn) in a cycle where busy and reqValid are both low stores hostWrKey at hostPage. hostRdKey always shows the key at hostPage.
- R12: A host write is ignored while busy is high, or when reqValid is high in the same cycle.
- R13: A request of the reserved kind 3 leaves the key unchanged and returns permOut equal to reqPerm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqAddr | input | ADDR_W | Absolute address of the access |
| reqKind | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| reqPerm | input | 3 | Permission flags from translation (exec, write, read) |
| memLimit | input | ADDR_W | Installed memory size in bytes |
| busy | output | 1 | Update in progress; requests are not accepted |
| respValid | output | 1 | One-cycle result strobe |
| permOut | output | 3 | Permission flags after the key check |
| hostWrEn | input | 1 | Direct key write strobe |
| hostPage | input | IDX_W | Page index for the direct port |
| hostWrKey | input | 7 | Key value to write |
| hostRdKey | output | 7 | Key value at hostPage |

## Verification
The bench builds the block with ADDR_W = 20, PAGE_BITS = 12 and NUM_PAGES = 16. Addresses up to 0x17FFF therefore reach every one of the 16 keys and also page numbers past the end of the array. A page past the end of the array aliases onto a real key in its low index bits, so a lookup that wrongly succeeds shows up as a change to that key. memLimit switches among values below, equal to and above the array size. This lets random traffic hit the memory-limit rejection, the failed-lookup rejection and the ordinary update path, and after each request the whole key array is compared through the host read port.

// File: rtl/skeyPkg.sv
package skeyPkg;

  localparam int KEY_W   = 7;
  localparam int PERM_W  = 3;
  localparam int CHG_BIT = 0;
  localparam int REF_BIT = 1;
  localparam int WR_BIT  = 1;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } accKind_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } updState_t;

  typedef struct packed {
    logic captureReq;
    logic latchKey;
    logic writeBack;
    logic hostWrite;
  } ctrlStrobes_t;

endpackage

// File: rtl/skeyKeyArray.sv
module skeyKeyArray #(
  parameter int NUM_PAGES = 64,
  parameter int IDX_W     = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [IDX_W-1:0]          wrIdx,
  input  logic [skeyPkg::KEY_W-1:0] wrData,
  input  logic [IDX_W-1:0]          rdIdxA,
  output logic [skeyPkg::KEY_W-1:0] rdDataA,
  input  logic [IDX_W-1:0]          rdIdxB,
  output logic [skeyPkg::KEY_W-1:0] rdDataB
);
  import skeyPkg::*;

  localparam logic [IDX_W:0] DEPTH = (IDX_W+1)'(NUM_PAGES);

  logic [KEY_W-1:0] keyMem [NUM_PAGES];

  generate
    for (genvar g = 0; g < NUM_PAGES; g++) begin : gEntry
      always_ff @(posedge clk) begin
        if (!rstN) begin
          keyMem[g] <= '0;
        end else if (wrEn && (wrIdx == IDX_W'(g))) begin
          keyMem[g] <= wrData;
        end
      end
    end
  endgenerate

  always_comb begin
    rdDataA = '0;
    rdDataB = '0;
    if ({1'b0, rdIdxA} < DEPTH) rdDataA = keyMem[rdIdxA];
    if ({1'b0, rdIdxB} < DEPTH) rdDataB = keyMem[rdIdxB];
  end

endmodule

// File: rtl/skeyCtrl.sv
module skeyCtrl (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic                  hostWrEn,
  output skeyPkg::ctrlStrobes_t strobes,
  output logic                  busy
);
  import skeyPkg::*;

  updState_t stateQ;
  updState_t stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (reqValid) stateD = ST_READ;
      ST_READ:  stateD = ST_WRITE;
      ST_WRITE: stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobes.captureReq = (stateQ == ST_IDLE) && reqValid;
    strobes.hostWrite  = (stateQ == ST_IDLE) && !reqValid && hostWrEn;
    strobes.latchKey   = (stateQ == ST_READ);
    strobes.writeBack  = (stateQ == ST_WRITE);
    busy               = (stateQ != ST_IDLE);
  end

endmodule

// File: rtl/skeyDatapath.sv
module skeyDatapath #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int NUM_PAGES = 64,
  parameter int IDX_W     = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  skeyPkg::ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0]          reqAddr,
  input  logic [1:0]                 reqKind,
  input  logic [skeyPkg::PERM_W-1:0] reqPerm,
  input  logic [ADDR_W-1:0]          memLimit,
  input  logic [IDX_W-1:0]           hostPage,
  input  logic [skeyPkg::KEY_W-1:0]  hostWrKey,
  output logic [skeyPkg::KEY_W-1:0]  hostRdKey,
  output logic                       respValid,
  output logic [skeyPkg::PERM_W-1:0] permOut
);
  import skeyPkg::*;

  localparam int PN_W = ADDR_W - PAGE_BITS;
  localparam logic [PN_W:0] PAGE_CNT = (PN_W+1)'(NUM_PAGES);

  logic [PN_W-1:0]   pageNum;
  logic              inArray;
  logic              belowLimit;

  logic [IDX_W-1:0]  idxQ;
  logic [1:0]        kindQ;
  logic [PERM_W-1:0] permQ;
  logic              hitQ;
  logic [KEY_W-1:0]  keyQ;

  logic [KEY_W-1:0]  keyRd;
  logic [KEY_W-1:0]  newKey;
  logic [PERM_W-1:0] newPerm;
  logic              keyDirty;

  logic              arrWrEn;
  logic [IDX_W-1:0]  arrWrIdx;
  logic [KEY_W-1:0]  arrWrData;

  assign pageNum    = reqAddr[ADDR_W-1:PAGE_BITS];
  assign inArray    = {1'b0, pageNum} < PAGE_CNT;
  assign belowLimit = reqAddr < memLimit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ  <= '0;
      kindQ <= '0;
      permQ <= '0;
      hitQ  <= 1'b0;
    end else if (strobes.captureReq) begin
      idxQ  <= pageNum[IDX_W-1:0];
      kindQ <= reqKind;
      permQ <= reqPerm;
      hitQ  <= inArray && belowLimit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 keyQ <= '0;
    else if (strobes.latchKey) keyQ <= keyRd;
  end

  always_comb begin
    newKey   = keyQ;
    newPerm  = permQ;
    keyDirty = 1'b0;
    if (hitQ) begin
      unique case (accKind_t'(kindQ))
        ACC_LOAD, ACC_FETCH: begin
          newKey[REF_BIT] = 1'b1;
          keyDirty        = 1'b1;
          if (!keyQ[CHG_BIT]) newPerm[WR_BIT] = 1'b0;
        end
        ACC_STORE: begin
          newKey[REF_BIT] = 1'b1;
          newKey[CHG_BIT] = 1'b1;
          keyDirty        = 1'b1;
        end
        default: keyDirty = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      permOut   <= '0;
    end else begin
      respValid <= strobes.writeBack;
      if (strobes.writeBack) permOut <= newPerm;
    end
  end

  always_comb begin
    arrWrEn   = strobes.hostWrite || (strobes.writeBack && keyDirty);
    arrWrIdx  = strobes.hostWrite ? hostPage  : idxQ;
    arrWrData = strobes.hostWrite ? hostWrKey : newKey;
  end

  skeyKeyArray #(
    .NUM_PAGES(NUM_PAGES),
    .IDX_W    (IDX_W)
  ) u_keys (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (arrWrEn),
    .wrIdx  (arrWrIdx),
    .wrData (arrWrData),
    .rdIdxA (idxQ),
    .rdDataA(keyRd),
    .rdIdxB (hostPage),
    .rdDataB(hostRdKey)
  );

endmodule

// File: rtl/skeyUpdater.sv
module skeyUpdater #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int NUM_PAGES = 64,
  localparam int IDX_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqKind,
  input  logic [2:0]        reqPerm,
  input  logic [ADDR_W-1:0] memLimit,
  output logic              busy,
  output logic              respValid,
  output logic [2:0]        permOut,
  input  logic              hostWrEn,
  input  logic [IDX_W-1:0]  hostPage,
  input  logic [6:0]        hostWrKey,
  output logic [6:0]        hostRdKey
);
  import skeyPkg::*;

  ctrlStrobes_t strobes;

  skeyCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .hostWrEn(hostWrEn),
    .strobes (strobes),
    .busy    (busy)
  );

  skeyDatapath #(
    .ADDR_W   (ADDR_W),
    .PAGE_BITS(PAGE_BITS),
    .NUM_PAGES(NUM_PAGES),
    .IDX_W    (IDX_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .reqAddr  (reqAddr),
    .reqKind  (reqKind),
    .reqPerm  (reqPerm),
    .memLimit (memLimit),
    .hostPage (hostPage),
    .hostWrKey(hostWrKey),
    .hostRdKey(hostRdKey),
    .respValid(respValid),
    .permOut  (permOut)
  );

endmodule

// File: rtl/skeyUpdaterChk.sv
module skeyUpdaterChk #(
  parameter int NUM_PAGES = 64,
  parameter int IDX_W     = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [1:0]       reqKind,
  input logic [2:0]       reqPerm,
  input logic             busy,
  input logic             respValid,
  input logic [2:0]       permOut,
  input logic             hostWrEn,
  input logic [IDX_W-1:0] hostPage,
  input logic [6:0]       hostWrKey,
  input logic [6:0]       hostRdKey
);

  // R9: busy lasts exactly two cycles
  a_r9_busy_two_cycles: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> busy ##1 !busy);

  // R9: the falling edge of busy comes with the result strobe
  a_r9_resp_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> respValid);

  // R9: no result strobe while busy
  a_r9_resp_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !busy);

  // R3: the block never adds a permission that the request lacked
  a_r3_no_added_perm: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> ((permOut & ~$past(reqPerm, 3)) == 3'b000));

  // R5: a store keeps its permissions
  a_r5_store_perm_kept: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && $past(reqKind, 3) == 2'd1) |-> permOut == $past(reqPerm, 3));

  // R11: an accepted host write is visible on the next cycle
  a_r11_host_write_seen: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && !busy && !reqValid && ({1'b0, hostPage} < (IDX_W+1)'(NUM_PAGES)))
      |=> (hostPage != $past(hostPage)) || (hostRdKey == $past(hostWrKey)));

endmodule

bind skeyUpdater skeyUpdaterChk #(
  .NUM_PAGES(NUM_PAGES),
  .IDX_W    (IDX_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqKind  (reqKind),
  .reqPerm  (reqPerm),
  .busy     (busy),
  .respValid(respValid),
  .permOut  (permOut),
  .hostWrEn (hostWrEn),
  .hostPage (hostPage),
  .hostWrKey(hostWrKey),
  .hostRdKey(hostRdKey)
);

// File: tb/skeyUpdater_tb.sv
`timescale 1ns/1ps
module skeyUpdater_tb;

  localparam int AW = 20;
  localparam int PB = 12;
  localparam int NP = 16;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [1:0]    reqKind = '0;
  logic [2:0]    reqPerm = '0;
  logic [AW-1:0] memLimit = 20'hE000;
  logic          busy;
  logic          respValid;
  logic [2:0]    permOut;
  logic          hostWrEn = 1'b0;
  logic [IW-1:0] hostPage = '0;
  logic [6:0]    hostWrKey = '0;
  logic [6:0]    hostRdKey;

  int checks = 0;
  int errors = 0;
  logic [6:0] model [NP];

  always #2.5 clk = ~clk;

  skeyUpdater #(.ADDR_W(AW), .PAGE_BITS(PB), .NUM_PAGES(NP)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqKind(reqKind), .reqPerm(reqPerm), .memLimit(memLimit), .busy(busy),
    .respValid(respValid), .permOut(permOut), .hostWrEn(hostWrEn),
    .hostPage(hostPage), .hostWrKey(hostWrKey), .hostRdKey(hostRdKey));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit isHit(input logic [AW-1:0] a, input logic [AW-1:0] lim);
    return (a < lim) && ((a >> PB) < NP);
  endfunction

  function automatic logic [2:0] expPerm(input logic [AW-1:0] a, input logic [1:0] k,
                                         input logic [2:0] p, input logic [AW-1:0] lim);
    if (!isHit(a, lim)) return p;
    if ((k == 2'd0 || k == 2'd2) && !model[a >> PB][0]) return p & 3'b101;
    return p;
  endfunction

  function automatic logic [6:0] expKey(input logic [AW-1:0] a, input logic [1:0] k,
                                        input logic [AW-1:0] lim);
    logic [6:0] key = model[(a >> PB) % NP];
    if (!isHit(a, lim)) return key;
    if (k == 2'd1) return key | 7'h03;
    if (k == 2'd3) return key;
    return key | 7'h02;
  endfunction

  function automatic string permTag(input logic [AW-1:0] a, input logic [1:0] k,
                                    input logic [AW-1:0] lim);
    if (a >= lim) return "R7";
    if ((a >> PB) >= NP) return "R8";
    if (k == 2'd1) return "R5";
    if (k == 2'd3) return "R13";
    if (!model[a >> PB][0]) return "R3";
    return "R4";
  endfunction

  task automatic checkAll(input string tag);
    for (int i = 0; i < NP; i++) begin
      hostPage = IW'(i);
      #0.1;
      check(hostRdKey == model[i], tag, int'(hostRdKey), int'(model[i]));
    end
  endtask

  task automatic hostWrite(input int pg, input logic [6:0] key);
    @(negedge clk);
    hostWrEn = 1'b1; hostPage = IW'(pg); hostWrKey = key;
    @(posedge clk);
    @(negedge clk);
    hostWrEn = 1'b0;
    model[pg] = key;
  endtask

  task automatic doReq(input logic [AW-1:0] a, input logic [1:0] k, input logic [2:0] p,
                       input bit intrude);
    logic [2:0] eP = expPerm(a, k, p, memLimit);
    logic [6:0] eK = expKey(a, k, memLimit);
    string t = permTag(a, k, memLimit);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqKind = k; reqPerm = p;
    @(posedge clk);
    @(negedge clk);
    reqValid = intrude;
    if (intrude) begin
      reqAddr = 20'h9000; reqKind = 2'd1;  // R10: store to page 9 while busy
      hostWrEn = 1'b1; hostPage = 4'd10; hostWrKey = 7'h7F;  // R12: host write while busy
    end
    check(busy === 1'b1, "R9 busy first cycle", int'(busy), 1);
    @(posedge clk);
    @(negedge clk);
    check(busy === 1'b1 && respValid === 1'b0, "R9 busy second cycle", int'({busy, respValid}), 2);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; hostWrEn = 1'b0;
    check(busy === 1'b0 && respValid === 1'b1, "R9 result strobe", int'({busy, respValid}), 1);
    check(permOut === eP, t, int'(permOut), int'(eP));
    if (isHit(a, memLimit)) model[a >> PB] = eK;
    @(posedge clk);
    @(negedge clk);
    check(respValid === 1'b0, "R9 single pulse", int'(respValid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NP; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check(busy === 1'b0 && respValid === 1'b0, "R1 idle after reset", int'({busy, respValid}), 0);
    checkAll("R1 keys zero");

    // R11 host port
    hostWrite(3, 7'h55);
    hostWrite(4, 7'h54);
    checkAll("R11 host write");

    doReq(20'h4ABC, 2'd0, 3'b111, 1'b0);  // R3 load, change clear
    doReq(20'h3010, 2'd0, 3'b111, 1'b0);  // R4 load, change set
    doReq(20'h5000, 2'd2, 3'b110, 1'b0);  // R3/R6 fetch
    checkAll("R6 reference set");
    doReq(20'h6FFF, 2'd1, 3'b011, 1'b0);  // R5 store
    checkAll("R2 only page 6 changed");
    doReq(20'h7000, 2'd3, 3'b111, 1'b0);  // R13 reserved
    checkAll("R13 key kept");
    doReq(20'hE123, 2'd1, 3'b111, 1'b0);  // R7 beyond limit
    checkAll("R7 keys kept");
    memLimit = 20'hFFFFF;
    doReq(20'h12345, 2'd1, 3'b111, 1'b0); // R8 page 18 aliases page 2
    checkAll("R8 keys kept");
    doReq(20'h2000, 2'd0, 3'b111, 1'b1);  // R10/R12 intruders
    checkAll("R10 R12 ignored while busy");

    // R12: host write with reqValid in the same idle cycle
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 20'h8000; reqKind = 2'd1; reqPerm = 3'b111;
    hostWrEn = 1'b1; hostPage = 4'd11; hostWrKey = 7'h70;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; hostWrEn = 1'b0;
    repeat (3) @(negedge clk);
    model[8] = model[8] | 7'h03;
    checkAll("R12 host loses to request");

    for (int n = 0; n < 300; n++) begin
      logic [AW-1:0] a = AW'($urandom % 32'h18000);
      logic [1:0] k = 2'($urandom);
      logic [2:0] p = 3'($urandom);
      int sel = $urandom % 4;
      memLimit = (sel == 0) ? 20'hE000 : (sel == 1) ? 20'h10000 :
                 (sel == 2) ? 20'h5000 : 20'hFFFFF;
      if ($urandom % 8 == 0) hostWrite(int'($urandom % NP), 7'($urandom));
      doReq(a, k, p, 1'b0);
      hostPage = IW'((a >> PB) % NP);
      #0.1;
      check(hostRdKey == model[(a >> PB) % NP], "R2 random key", int'(hostRdKey),
            int'(model[(a >> PB) % NP]));
    end
    checkAll("R2 final array");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule